// File: doc/BRIEF.md
# Serial ADC Frame Reader

This block reads an 8-bit serial analog-to-digital converter and holds the latest result for a display. Every timing signal comes from one free-running counter clocked by the master clock. The serial clock, the active-low converter select, the sampling instant and the capture instant are each a fixed decode of counter bits. There is no explicit state machine.

A frame is 256 master cycles long. The converter is selected for the first 192 counts and deselected, and so held in reset, for the last 64. A shift register samples the serial data line at every falling edge of the serial clock. Near the end of the select window, the word it holds is copied into a parallel hold register. The hold register drives the display and keeps its value until the next frame's capture. A decimal-point enable for the display is tied active.

The converter may change its data on the rising edge of the serial clock. The first two sampled bits of a frame are leading null bits. The next eight are the result, most significant bit first. The serial input passes through a small synchronizer before it is sampled.

Top module: `adcr_reader`

## Requirements
- R1: While `rst_n` is low, `disp_value` is 0 (cleared asynchronously), `adc_sclk` is 0 and `adc_cs_n` is 0. After release, the frame counter starts from count 0.
- R2: `adc_sclk` equals bit 3 of the frame counter. It is low for 8 master cycles and then high for 8 master cycles, repeating every 16 cycles.
- R3: `adc_cs_n` is high exactly when the two top counter bits are both 1. That is counts 192 to 255: low for 192 cycles and high for 64 cycles in every 256-cycle frame.
- R4: The serial input is sampled once per serial-clock period, at the master edge where `adc_sclk` falls. Data that is stable from the preceding `adc_sclk` rise onward is taken correctly, including the delay of the 2-stage input synchronizer.
- R5: At the `adc_sclk` fall that ends counter slot 1010 (the edge from count 175 to 176), `disp_value` loads the shift register as it stood before that edge. This puts the new value on `disp_value` at count 176.
- R6: `disp_value` changes at most once per 256-cycle frame, and only at the capture edge of R5. Serial-data activity at all other times has no effect on it.
- R7: `dp_on` is constantly 1.
- R8: The captured word is made of the 3rd through 10th samples of the frame, 3rd sample in bit 7 and 10th sample in bit 0. The 1st and 2nd samples, and samples 11 and later, do not affect the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| adc_sdata | input | 1 | Serial data from the converter |
| adc_sclk | output | 1 | Serial clock to the converter (master clock / 16) |
| adc_cs_n | output | 1 | Active-low converter select |
| disp_value | output | 8 | Held conversion result for the display |
| dp_on | output | 1 | Decimal-point enable, always 1 |

## Verification
The serial clock and select are due in the same cycle as the counter value that decodes them. A new held value is due exactly 176 master cycles after the select falls. After `rst_n` rises, the count starts two cycles later because of the reset synchronizer. The bench therefore never counts cycles from reset release. It aligns to the observed select edges and then tracks the counter position itself, sampling at the falling master-clock edge. At each position it compares `adc_sclk` and `adc_cs_n` against that count, and it records the cycle at which `disp_value` changes so the capture instant is checked exactly. The serial stub drives random junk into the null and trailing bit slots, so a wrong sampling window shows up as a wrong captured word.

// File: rtl/adcr_pkg.sv
package adcr_pkg;

  // Default geometry of the frame reader
  localparam int ADCR_CNT_W       = 8;   // frame counter width
  localparam int ADCR_DATA_W      = 8;   // converted word width
  localparam int ADCR_SCLK_BIT    = 3;   // counter bit used as serial clock
  localparam int ADCR_SEL_W       = 2;   // top counter bits that deselect when all set
  localparam int ADCR_CAP_SLOT    = 10;  // counter slot whose last sclk fall captures
  localparam int ADCR_SYNC_STAGES = 2;   // serial input synchronizer depth

  // Strobes decoded from the frame counter
  typedef struct packed {
    logic sclk;        // serial clock level
    logic cs_n;        // registered active-low select
    logic fall_en;     // sclk falls at the next master edge
    logic capture_en;  // this fall is the capture instant
  } adcr_tick_t;

endpackage

// File: rtl/adcr_rst_sync.sv
module adcr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = STAGES'({sync_q, 1'b1});
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_n = sync_q[STAGES-1];

endmodule

// File: rtl/adcr_timebase.sv
module adcr_timebase
  import adcr_pkg::*;
#(
  parameter int CNT_W    = ADCR_CNT_W,
  parameter int SCLK_BIT = ADCR_SCLK_BIT,
  parameter int SEL_W    = ADCR_SEL_W,
  parameter int CAP_SLOT = ADCR_CAP_SLOT
) (
  input  logic       clk,
  input  logic       rst_n,
  output adcr_tick_t tick
);

  localparam int PHASE_W = SCLK_BIT + 1;     // bits below and including sclk
  localparam int SLOT_W  = CNT_W - PHASE_W;  // one slot per sclk period

  logic [CNT_W-1:0]  cnt_q;
  logic [CNT_W-1:0]  cnt_d;
  logic              csn_q;
  logic              csn_d;
  logic [SLOT_W-1:0] slot;
  logic              phase_end;

  // Next-state logic: free-running count and select lookahead
  always_comb begin
    cnt_d = cnt_q + 1'b1;
    csn_d = &cnt_d[CNT_W-1 -: SEL_W];
  end

  // Register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      csn_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      csn_q <= csn_d;
    end
  end

  // Strobe decode
  always_comb begin
    slot            = cnt_q[CNT_W-1 -: SLOT_W];
    phase_end       = &cnt_q[SCLK_BIT:0];
    tick.sclk       = cnt_q[SCLK_BIT];
    tick.cs_n       = csn_q;
    tick.fall_en    = phase_end;
    tick.capture_en = phase_end && (slot == SLOT_W'(CAP_SLOT));
  end

endmodule

// File: rtl/adcr_shifter.sv
module adcr_shifter #(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sdata,
  input  logic              shift_en,
  output logic [DATA_W-1:0] word
);

  logic              sd_sync;
  logic [DATA_W-1:0] sh_q;
  logic [DATA_W-1:0] sh_d;

  generate
    if (SYNC_STAGES == 0) begin : g_nosync
      assign sd_sync = sdata;
    end else begin : g_sync
      logic [SYNC_STAGES-1:0] sy_q;
      logic [SYNC_STAGES-1:0] sy_d;
      always_comb begin
        sy_d = SYNC_STAGES'({sy_q, sdata});
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          sy_q <= '0;
        end else begin
          sy_q <= sy_d;
        end
      end
      assign sd_sync = sy_q[SYNC_STAGES-1];
    end
  endgenerate

  // Next-state: shift in MSB first when enabled
  always_comb begin
    sh_d = sh_q;
    if (shift_en) begin
      sh_d = {sh_q[DATA_W-2:0], sd_sync};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q <= '0;
    end else begin
      sh_q <= sh_d;
    end
  end

  assign word = sh_q;

endmodule

// File: rtl/adcr_hold.sv
module adcr_hold #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_en,
  input  logic [DATA_W-1:0] load_val,
  output logic [DATA_W-1:0] held
);

  logic [DATA_W-1:0] hold_q;
  logic [DATA_W-1:0] hold_d;

  always_comb begin
    hold_d = hold_q;
    if (load_en) begin
      hold_d = load_val;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
    end else begin
      hold_q <= hold_d;
    end
  end

  assign held = hold_q;

endmodule

// File: rtl/adcr_reader.sv
module adcr_reader
  import adcr_pkg::*;
#(
  parameter int CNT_W       = ADCR_CNT_W,
  parameter int DATA_W      = ADCR_DATA_W,
  parameter int SCLK_BIT    = ADCR_SCLK_BIT,
  parameter int SEL_W       = ADCR_SEL_W,
  parameter int CAP_SLOT    = ADCR_CAP_SLOT,
  parameter int SYNC_STAGES = ADCR_SYNC_STAGES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              adc_sdata,
  output logic              adc_sclk,
  output logic              adc_cs_n,
  output logic [DATA_W-1:0] disp_value,
  output logic              dp_on
);

  logic              rst_sync_n;
  adcr_tick_t        tick;
  logic [DATA_W-1:0] shreg_word;
  logic [DATA_W-1:0] held_word;
  logic              hold_rst_n;

  adcr_rst_sync #(.STAGES(2)) u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .rst_n  (rst_sync_n)
  );

  adcr_timebase #(
    .CNT_W    (CNT_W),
    .SCLK_BIT (SCLK_BIT),
    .SEL_W    (SEL_W),
    .CAP_SLOT (CAP_SLOT)
  ) u_tb (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .tick  (tick)
  );

  adcr_shifter #(
    .DATA_W      (DATA_W),
    .SYNC_STAGES (SYNC_STAGES)
  ) u_sh (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .sdata    (adc_sdata),
    .shift_en (tick.fall_en),
    .word     (shreg_word)
  );

  // Display register clears as soon as the external reset asserts
  assign hold_rst_n = rst_sync_n & rst_n;

  adcr_hold #(.DATA_W(DATA_W)) u_hold (
    .clk      (clk),
    .rst_n    (hold_rst_n),
    .load_en  (tick.capture_en),
    .load_val (shreg_word),
    .held     (held_word)
  );

  assign adc_sclk   = tick.sclk;
  assign adc_cs_n   = tick.cs_n;
  assign disp_value = held_word;
  assign dp_on      = 1'b1;

endmodule

// File: rtl/adcr_reader_chk.sv
module adcr_reader_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sclk,
  input logic              cs_n,
  input logic              fall_en,
  input logic              capture_en,
  input logic [DATA_W-1:0] shreg,
  input logic [DATA_W-1:0] disp
);

  // R4: a sampling strobe coincides with the serial clock falling
  assert_sample_on_fall_R4: assert property (@(posedge clk) disable iff (!rst_n)
    fall_en |=> $fell(sclk));

  // R2: serial clock stays high for more than one master cycle
  assert_sclk_width_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sclk) |=> sclk);

  // R3: deselect happens while the serial clock is low
  assert_deselect_clk_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n) |-> !sclk);

  // R5: capture happens inside the select window
  assert_capture_selected_R5: assert property (@(posedge clk) disable iff (!rst_n)
    capture_en |-> !cs_n);

  // R5: held value equals the shift register before the capture edge
  assert_capture_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
    capture_en |=> disp == $past(shreg));

  // R6: held value is stable outside capture
  assert_hold_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !capture_en |=> $stable(disp));

endmodule

bind adcr_reader adcr_reader_chk #(.DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst_n      (hold_rst_n),
  .sclk       (adc_sclk),
  .cs_n       (adc_cs_n),
  .fall_en    (tick.fall_en),
  .capture_en (tick.capture_en),
  .shreg      (shreg_word),
  .disp       (disp_value)
);

// File: tb/sim_adcr_reader.sv
module sim_adcr_reader;

  logic       clk;
  logic       rst_n;
  logic       adc_sdata;
  logic       adc_sclk;
  logic       adc_cs_n;
  logic [7:0] disp_value;
  logic       dp_on;

  int         checks;
  int         errors;
  int         cyc;
  bit         done;
  logic [7:0] code;
  logic [7:0] prev;
  int         idx;

  adcr_reader u0 (
    .clk        (clk),
    .rst_n      (rst_n),
    .adc_sdata  (adc_sdata),
    .adc_sclk   (adc_sclk),
    .adc_cs_n   (adc_cs_n),
    .disp_value (disp_value),
    .dp_on      (dp_on)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // Serial converter stub: new bit on each sclk rise; slots 2..9 carry the word
  always @(posedge adc_sclk or posedge adc_cs_n or negedge rst_n) begin
    if (!rst_n || adc_cs_n) begin
      idx <= 0;
    end else begin
      adc_sdata <= (idx >= 2 && idx <= 9) ? code[9 - idx] : 1'($urandom);
      idx       <= idx + 1;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [7:0] pick_code(input int n, input logic [7:0] last);
    logic [7:0] c;
    case (n)
      0: c = 8'hFF;
      1: c = 8'h00;
      2: c = 8'h80;
      3: c = 8'h01;
      4: c = 8'hA5;
      5: c = 8'h5A;
      6: c = 8'h7F;
      7: c = 8'hFE;
      default: c = 8'($urandom);
    endcase
    if (c == last) c = ~last;
    return c;
  endfunction

  task automatic wait_level(input logic lvl);
    while (adc_cs_n !== lvl) @(negedge clk);
  endtask

  // Runs one frame from count 0; code must already be set
  task automatic run_frame(input bool_dummy);
    int chg, chg_k, sclk_bad, cs_bad;
    logic [7:0] last_disp;
    chg = 0; chg_k = -1; sclk_bad = 0; cs_bad = 0;
    last_disp = disp_value;
    for (int k = 0; k < 256; k++) begin
      if (adc_sclk !== ((k >> 3) & 1)) sclk_bad++;
      if (adc_cs_n !== (k >= 192)) cs_bad++;
      if (disp_value !== last_disp) begin
        chg++;
        chg_k = k;
        last_disp = disp_value;
      end
      if (k == 100) check(disp_value == prev, "R6 mid-frame hold", disp_value, prev);
      @(negedge clk);
    end
    check(sclk_bad == 0, "R2 sclk pattern", sclk_bad, 0);
    check(cs_bad == 0, "R3 select pattern", cs_bad, 0);
    check(disp_value == code, "R4 captured word", disp_value, code);
    check(disp_value == code, "R8 junk slots ignored", disp_value, code);
    check(chg == 1, "R6 one change per frame", chg, 1);
    check(chg_k == 176, "R5 capture count", chg_k, 176);
    check(dp_on == 1'b1, "R7 dp", dp_on, 1);
  endtask

  initial begin
    cyc = 0;
    done = 1'b0;
    while (!done && cyc < 200000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 200000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    checks = 0; errors = 0;
    rst_n = 1'b0; adc_sdata = 1'b0; code = 8'h3C; prev = 8'h00;
    repeat (5) @(negedge clk);
    check(disp_value == 8'h00, "R1 reset disp", disp_value, 0);
    check(adc_sclk == 1'b0, "R1 reset sclk", adc_sclk, 0);
    check(adc_cs_n == 1'b0, "R1 reset select", adc_cs_n, 0);
    check(dp_on == 1'b1, "R7 dp in reset", dp_on, 1);
    rst_n = 1'b1;

    // First frame after reset, then align on select falling
    wait_level(1'b1);
    check(disp_value == code, "R4 first frame", disp_value, code);
    wait_level(1'b0);
    for (int f = 0; f < 14; f++) begin
      prev = code;
      code = pick_code(f, prev);
      run_frame(1'b0);
    end

    // Reset in the middle of a frame clears the display at once
    repeat (100) @(negedge clk);
    rst_n = 1'b0;
    #1;
    check(disp_value == 8'h00, "R1 async clear", disp_value, 0);
    repeat (3) @(negedge clk);
    check(adc_cs_n == 1'b0 && adc_sclk == 1'b0, "R1 outputs in reset",
          {adc_cs_n, adc_sclk}, 0);
    prev = code;
    code = pick_code(99, prev);
    rst_n = 1'b1;
    wait_level(1'b1);
    check(disp_value == code, "R4 frame after reset", disp_value, code);
    wait_level(1'b0);
    for (int f = 0; f < 10; f++) begin
      prev = code;
      code = pick_code(20 + f, prev);
      run_frame(1'b0);
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule